// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between an on-chip request port and an external asynchronous static RAM with 131072 byte locations (17-bit address, 8-bit data). A requester offers one transfer at a time with a valid/ready handshake. The transfer is either a byte write or a byte read. The controller turns it into a strobe sequence on the memory pins, with every window counted in whole clock cycles. The memory has two chip selects of opposite polarity. The controller moves them together, so the device is either fully selected or fully in standby.

A central state machine orders each transfer. Its states are IDLE, READ_WAIT, READ_CAPTURE, WRITE_SETUP, WRITE_PULSE and TURNAROUND. It moves through them as follows:
- IDLE to READ_WAIT on an accepted read. It goes straight to READ_CAPTURE when the access takes a single cycle.
- READ_WAIT to READ_CAPTURE when the wait timer expires.
- READ_CAPTURE to TURNAROUND.
- IDLE to WRITE_SETUP on an accepted write.
- WRITE_SETUP to WRITE_PULSE.
- WRITE_PULSE to TURNAROUND when the pulse timer expires.
- TURNAROUND to IDLE when the turnaround timer expires.

All memory pins come from flops loaded from the next state, so the pins never glitch. The parameters RD_CYC, WP_CYC and TA_CYC give the access time, the write pulse width and the bus release time in clock cycles, rounded up from nanoseconds. The defaults suit a 20 ns clock with a 35 ns part: RD_CYC=2, WP_CYC=2 and TA_CYC=1. Each parameter must be at least 1.

Top module: `asram_ctrl`

## Requirements
- R1: During reset and while idle, the memory is in standby. This means mem_ce_n=1, mem_ce=0, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0. req_ready is 1 while idle.
- R2: req_ready is 1 only in IDLE. A request is taken on a rising edge where req_valid and req_ready are both 1. While a request waits, it stays pending and is not lost.
- R3: After a read (req_write=0) is accepted, the next RD_CYC cycles show the device selected, mem_oe_n=0, mem_we_n=1 and mem_addr equal to the request address.
- R4: The controller samples mem_dq_in at the end of the last mem_oe_n=0 cycle. rsp_valid then pulses high for exactly one cycle, RD_CYC+1 cycles after acceptance, with that byte on rsp_rdata.
- R5: After a write (req_write=1) is accepted, one setup cycle follows. In it the device is selected, the address is valid and both strobes are high. Then mem_we_n is 0 for WP_CYC cycles. mem_oe_n stays 1 for the whole write.
- R6: mem_dq_oe is 1 exactly in the cycles where mem_we_n is 0, and in those cycles mem_dq_out equals the write data.
- R7: wr_done pulses high for one cycle, in the cycle where mem_we_n has just returned high, which is WP_CYC+2 cycles after acceptance.
- R8: After every transfer, the device stays deselected with the bus released for TA_CYC cycles before req_ready returns to 1.
- R9: While the device is selected, mem_addr does not change. req_addr, req_wdata and req_write have no effect while the block is busy.
- R10: mem_dq_oe=1 and mem_oe_n=0 never occur in the same cycle, and mem_ce_n always equals the inverse of mem_ce.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 8 | Read byte |
| wr_done | output | 1 | One-cycle write completion strobe |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pad |
| mem_dq_in | input | 8 | Data from memory pad |

## Verification
Counted from the accepting clock edge, a read produces the following:
- mem_oe_n is low in cycles 1 to RD_CYC.
- rsp_valid appears in cycle RD_CYC+1.
- req_ready returns in cycle RD_CYC+TA_CYC+1.

A write produces the following:
- A setup cycle in cycle 1.
- The write pulse in cycles 2 to WP_CYC+1.
- wr_done in cycle WP_CYC+2.
- req_ready again after TA_CYC more cycles.

The bench keeps a behavioural model made of a cycle index per transfer and a reference byte map. It steps this model on the falling edge and compares every pin against it in every cycle. Because all outputs change only on rising edges, each expected value lines up with the exact cycle the timeline above predicts. The bench also plays the RAM: it returns data only while the read conditions hold and commits a byte when mem_we_n rises.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RD_WAIT   = 3'd1,
        ST_RD_CAP    = 3'd2,
        ST_WR_SETUP  = 3'd3,
        ST_WR_PULSE  = 3'd4,
        ST_TURN      = 3'd5
    } ctl_state_t;
endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_rd_capture.sv
`timescale 1ns/1ps
module asram_rd_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] pad_in,
    output logic          strobe,
    output logic [DW-1:0] byte_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe <= 1'b0;
            byte_q <= '0;
        end else begin
            strobe <= take;
            if (take) begin
                byte_q <= pad_in;
            end
        end
    end
endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int AW     = 17,
    parameter int DW     = 8,
    parameter int RD_CYC = 2,
    parameter int WP_CYC = 2,
    parameter int TA_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          wr_done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_ce,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);
    localparam int MAX_CYC = (RD_CYC > WP_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                               : ((WP_CYC > TA_CYC) ? WP_CYC : TA_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'((RD_CYC >= 2) ? RD_CYC - 2 : 0);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'((WP_CYC >= 1) ? WP_CYC - 1 : 0);
    localparam logic [CNT_W-1:0] TA_LOAD = CNT_W'((TA_CYC >= 1) ? TA_CYC - 1 : 0);

    ctl_state_t       state, state_nx;
    logic             accept;
    logic             t_load, t_expired;
    logic [CNT_W-1:0] t_val;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (req_write)        state_nx = ST_WR_SETUP;
                    else if (RD_CYC >= 2) state_nx = ST_RD_WAIT;
                    else                  state_nx = ST_RD_CAP;
                end
            end
            ST_RD_WAIT:  if (t_expired) state_nx = ST_RD_CAP;
            ST_RD_CAP:   state_nx = ST_TURN;
            ST_WR_SETUP: state_nx = ST_WR_PULSE;
            ST_WR_PULSE: if (t_expired) state_nx = ST_TURN;
            ST_TURN:     if (t_expired) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Timer reload on every state change, value picked by the state entered
    assign t_load = (state_nx != state);
    always_comb begin
        unique case (state_nx)
            ST_RD_WAIT:  t_val = RD_LOAD;
            ST_WR_PULSE: t_val = WP_LOAD;
            ST_TURN:     t_val = TA_LOAD;
            default:     t_val = '0;
        endcase
    end

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Pin and strobe registers, loaded from the state being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            mem_ce_n   <= 1'b1;
            mem_ce     <= 1'b0;
            mem_oe_n   <= 1'b1;
            mem_we_n   <= 1'b1;
            mem_dq_oe  <= 1'b0;
            wr_done    <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
            unique case (state_nx)
                ST_RD_WAIT, ST_RD_CAP: begin
                    mem_ce_n  <= 1'b0;
                    mem_ce    <= 1'b1;
                    mem_oe_n  <= 1'b0;
                    mem_we_n  <= 1'b1;
                    mem_dq_oe <= 1'b0;
                end
                ST_WR_SETUP: begin
                    mem_ce_n  <= 1'b0;
                    mem_ce    <= 1'b1;
                    mem_oe_n  <= 1'b1;
                    mem_we_n  <= 1'b1;
                    mem_dq_oe <= 1'b0;
                end
                ST_WR_PULSE: begin
                    mem_ce_n  <= 1'b0;
                    mem_ce    <= 1'b1;
                    mem_oe_n  <= 1'b1;
                    mem_we_n  <= 1'b0;
                    mem_dq_oe <= 1'b1;
                end
                default: begin
                    mem_ce_n  <= 1'b1;
                    mem_ce    <= 1'b0;
                    mem_oe_n  <= 1'b1;
                    mem_we_n  <= 1'b1;
                    mem_dq_oe <= 1'b0;
                end
            endcase
            wr_done <= (state == ST_WR_PULSE) && (state_nx == ST_TURN);
        end
    end

    asram_rd_capture #(.DW(DW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (state == ST_RD_CAP),
        .pad_in (mem_dq_in),
        .strobe (rsp_valid),
        .byte_q (rsp_rdata)
    );
endmodule

// File: rtl/asram_ctrl_chk.sv
`timescale 1ns/1ps
module asram_ctrl_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          wr_done,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ce_n,
    input logic          mem_ce,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_dq_oe
);
    a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r4_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r5_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    a_r6_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n && mem_ce));

    a_r7_done_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> (mem_we_n && $past(!mem_we_n)));

    a_r9_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));

    a_r10_selects_paired: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n == !mem_ce);
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .wr_done   (wr_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RD = 2;
    localparam int WP = 2;
    localparam int TA = 1;
    localparam int NOPS = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid, req_ready, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          rsp_valid, wr_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    always #10 clk = ~clk;

    asram_ctrl #(.AW(AW), .DW(DW), .RD_CYC(RD), .WP_CYC(WP), .TA_CYC(TA)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_done(wr_done),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int total_cnt = 0;
    int bad_cnt   = 0;
    bit finished  = 1'b0;

    logic [DW-1:0] ram_img [int];
    logic [DW-1:0] ref_img [int];

    bit            op_wr  [NOPS];
    logic [AW-1:0] op_a   [NOPS];
    logic [DW-1:0] op_d   [NOPS];
    int            op_gap [NOPS];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
        $finish;
    endtask

    task automatic check_standby(input string tag);
        chk(mem_ce_n == 1'b1,  {tag, " ce_n"},  mem_ce_n,  1);
        chk(mem_ce == 1'b0,    {tag, " ce"},    mem_ce,    0);
        chk(mem_oe_n == 1'b1,  {tag, " oe_n"},  mem_oe_n,  1);
        chk(mem_we_n == 1'b1,  {tag, " we_n"},  mem_we_n,  1);
        chk(mem_dq_oe == 1'b0, {tag, " dq_oe"}, mem_dq_oe, 0);
        chk(req_ready == 1'b1, {tag, " ready"}, req_ready, 1);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total_cnt++;
            bad_cnt++;
            $display("FAIL watchdog act=running exp=done");
            summary();
        end
    end

    initial begin
        bit            busy, is_wr, pend, ram_pv;
        int            k, tot, idx, gap_cnt, tail;
        logic [AW-1:0] cur_a, ram_pa;
        logic [DW-1:0] cur_d, exp_rd, ram_pd;
        bit            e_sel, e_oe, e_we, e_rsp, e_done;

        op_wr[0]  = 1; op_a[0]  = 17'h00000; op_d[0]  = 8'hA5; op_gap[0]  = 0;
        op_wr[1]  = 1; op_a[1]  = 17'h1FFFF; op_d[1]  = 8'h3C; op_gap[1]  = 0;
        op_wr[2]  = 0; op_a[2]  = 17'h1FFFF; op_d[2]  = 8'h00; op_gap[2]  = 2;
        op_wr[3]  = 0; op_a[3]  = 17'h00000; op_d[3]  = 8'h00; op_gap[3]  = 0;
        op_wr[4]  = 1; op_a[4]  = 17'h12345; op_d[4]  = 8'h7E; op_gap[4]  = 3;
        op_wr[5]  = 1; op_a[5]  = 17'h12345; op_d[5]  = 8'h81; op_gap[5]  = 0;
        op_wr[6]  = 0; op_a[6]  = 17'h12345; op_d[6]  = 8'h00; op_gap[6]  = 0;
        op_wr[7]  = 0; op_a[7]  = 17'h00777; op_d[7]  = 8'h00; op_gap[7]  = 1;
        op_wr[8]  = 1; op_a[8]  = 17'h0ABCD; op_d[8]  = 8'hFF; op_gap[8]  = 0;
        op_wr[9]  = 0; op_a[9]  = 17'h0ABCD; op_d[9]  = 8'h00; op_gap[9]  = 0;
        op_wr[10] = 1; op_a[10] = 17'h15555; op_d[10] = 8'h00; op_gap[10] = 4;
        op_wr[11] = 0; op_a[11] = 17'h15555; op_d[11] = 8'h00; op_gap[11] = 0;
        op_wr[12] = 0; op_a[12] = 17'h1FFFF; op_d[12] = 8'h00; op_gap[12] = 0;
        op_wr[13] = 1; op_a[13] = 17'h0AAAA; op_d[13] = 8'h5A; op_gap[13] = 2;

        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; mem_dq_in = '0;
        busy = 0; is_wr = 0; pend = 0; ram_pv = 0; k = 0; tot = 0;
        idx = 0; gap_cnt = 0; tail = 0; cur_a = '0; cur_d = '0; exp_rd = '0;
        ram_pa = '0; ram_pd = '0;

        repeat (3) @(negedge clk);
        check_standby("R1 reset");
        rst_n = 1'b1;

        while (idx < NOPS || busy || pend || tail < 3) begin
            @(negedge clk);
            if (idx >= NOPS && !busy && !pend) tail++;

            // RAM model: latch data during the pulse, commit on release
            if (!mem_we_n && !mem_ce_n && mem_ce && mem_dq_oe) begin
                ram_pv = 1; ram_pa = mem_addr; ram_pd = mem_dq_out;
            end else if (ram_pv && mem_we_n) begin
                ram_img[int'(ram_pa)] = ram_pd; ram_pv = 0;
            end
            if (!mem_ce_n && mem_ce && !mem_oe_n && mem_we_n)
                mem_dq_in = ram_img.exists(int'(mem_addr)) ? ram_img[int'(mem_addr)] : '0;
            else
                mem_dq_in = '0;

            // Expected pins for this cycle
            e_sel = 0; e_oe = 0; e_we = 0; e_rsp = 0; e_done = 0;
            if (busy && !is_wr) begin
                e_sel = (k <= RD); e_oe = (k <= RD); e_rsp = (k == RD + 1);
            end else if (busy && is_wr) begin
                e_sel = (k <= 1 + WP); e_we = (k >= 2 && k <= 1 + WP); e_done = (k == WP + 2);
            end
            chk(req_ready == !busy, "R2/R8 ready", req_ready, !busy);
            chk(mem_ce == e_sel, "R3/R5/R8 ce", mem_ce, e_sel);
            chk(mem_ce_n == !mem_ce, "R10 ce pair", mem_ce_n, !mem_ce);
            chk(mem_oe_n == !e_oe, "R3/R5 oe_n", mem_oe_n, !e_oe);
            chk(mem_we_n == !e_we, "R5 we_n", mem_we_n, !e_we);
            chk(mem_dq_oe == e_we, "R6 dq_oe", mem_dq_oe, e_we);
            chk(!(mem_dq_oe && !mem_oe_n), "R10 contention", mem_dq_oe, 0);
            chk(rsp_valid == e_rsp, "R4 rsp_valid", rsp_valid, e_rsp);
            chk(wr_done == e_done, "R7 wr_done", wr_done, e_done);
            if (e_sel) chk(mem_addr == cur_a, "R9 addr", mem_addr, cur_a);
            if (e_we)  chk(mem_dq_out == cur_d, "R6 dq_out", mem_dq_out, cur_d);
            if (e_rsp) chk(rsp_rdata == exp_rd, "R4 rdata", rsp_rdata, exp_rd);

            // Stimulus for the edge that ends this cycle
            if (!pend && idx < NOPS) begin
                if (gap_cnt >= op_gap[idx]) pend = 1;
                else gap_cnt++;
            end
            if (pend) begin
                req_valid = 1; req_write = op_wr[idx]; req_addr = op_a[idx]; req_wdata = op_d[idx];
            end else begin
                req_valid = 0; req_write = ~req_write;
                req_addr = req_addr ^ 17'h1B6D3; req_wdata = req_wdata + 8'h35;
            end

            // Advance the reference model
            if (busy) begin
                k++;
                if (k > tot) busy = 0;
            end else if (pend) begin
                busy = 1; k = 1; is_wr = op_wr[idx]; cur_a = op_a[idx]; cur_d = op_d[idx];
                tot = is_wr ? (1 + WP + TA) : (RD + TA);
                if (is_wr) ref_img[int'(cur_a)] = cur_d;
                else exp_rd = ref_img.exists(int'(cur_a)) ? ref_img[int'(cur_a)] : '0;
                pend = 0; idx++; gap_cnt = 0;
            end
        end

        // Reset while a write pulse is active
        req_valid = 1; req_write = 1; req_addr = 17'h01234; req_wdata = 8'hC3;
        @(negedge clk);
        req_valid = 0;
        repeat (2) @(negedge clk);
        chk(mem_we_n == 1'b0, "R5 pulse before reset", mem_we_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_standby("R1 mid-write reset");
        chk(wr_done == 1'b0, "R1 no done on reset", wr_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_standby("R1 after reset");

        finished = 1'b1;
        summary();
    end
endmodule